// File: doc/BRIEF.md
# Descriptor-Chained Scatter-Gather DMA Engine

This block is the bus-master half of a storage command path. A protocol controller first arms it with a command: the transfer direction, the byte budget the command allows, and the first sector address. Software then supplies the base of a descriptor table and pulses the start strobe. The engine walks the table one 8-byte descriptor at a time. For each descriptor it issues one memory transfer covering the descriptor's region. It also steps a per-sector storage port once for every 512-byte sector in that region. The walk stops at the descriptor that carries the end-of-table flag.

The engine is a single state machine with eleven states. **IDLE** goes to **ARMED** on `arm`. **ARMED** goes to **FETCH_REQ** on `go`. **FETCH_REQ** goes to **FETCH_WAIT** when the memory port is free, and to **FETCH_BO** (back-off) when it is busy; **FETCH_BO** returns to **FETCH_REQ** once the back-off expires. **FETCH_WAIT** goes to **DESC_CHK** on `mem_ack`. **DESC_CHK** returns to IDLE with an error, or moves on to the data phase. For a memory-to-storage command the data phase is **XFER_REQ**, then **XFER_WAIT**, then **SECT**. For a storage-to-memory command it is **SECT**, then **XFER_REQ**, then **XFER_WAIT**. **XFER_REQ** has its own back-off state, **XFER_BO**. The data phase ends in **NEXT**. **NEXT** either loops to FETCH_REQ or returns to IDLE with `done` or an error. `abort` sends every non-idle state to IDLE.

A memory transfer is not complete until two things have happened: the memory acknowledge has arrived, and a latency of `SECTOR_LAT` cycles per sector has elapsed.

Top module: `sgdma_engine`

## Requirements
- R1: `phase` reads 0 in IDLE, 1 in ARMED and 2 in every other state. `arm` is taken only in IDLE, and it makes `phase` read 1 one cycle later. `go` is taken only in ARMED. A `go` seen in IDLE is ignored: no memory request follows.
- R2: Each descriptor fetch is a memory read (`mem_we`=0, `mem_len`=8) at the table pointer. The pointer starts at `go_table` and grows by 8 after each fetched descriptor.
- R3: Descriptor word layout: bits 31:0 hold the region base with bit 0 ignored (the data request address has bit 0 cleared). Bits 47:32 hold the byte count, where 0 means 65536. Bit 63 is the end-of-table flag.
- R4: With `arm_to_mem`=1, the data request has `mem_we`=1, `stor_wr`=0, and the descriptor's storage strobes come before its memory request. With `arm_to_mem`=0, the data request has `mem_we`=0, `stor_wr`=1, and the strobes follow the transfer's completion.
- R5: `mem_req` is never high while `mem_busy` is high. When the port is found busy, the request is retried `BACKOFF`+1 cycles after the first attempt.
- R6: One `stor_stb` cycle is issued per 512 bytes. `stor_lba` starts at `arm_lba` and increases by one for each strobe across all descriptors.
- R7: A data transfer of n sectors is complete no sooner than n·`SECTOR_LAT` cycles after its request. In the memory-to-storage direction, the first strobe comes exactly n·`SECTOR_LAT`+2 cycles after the request cycle.
- R8: A descriptor without the end flag is followed by a fetch of the next one. After the end-flag descriptor, if the remaining budget is zero, `done` pulses and the engine returns to IDLE.
- R9: A byte count that is not a multiple of 512 ends the command with `err_code`=2 and no data request.
- R10: A byte count larger than the remaining budget ends the command with `err_code`=3 and no data request.
- R11: An end-flag descriptor that leaves budget unused ends the command with `err_code`=4.
- R12: `abort` in ARMED or in any transfer state ends the command with `err_code`=1. `abort` in IDLE has no effect: `err` stays low.
- R13: `done` and `err` are single-cycle pulses. They are never high together, and they appear in the first IDLE cycle. `err_code` is 0 whenever `err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Arm a command (taken in IDLE) |
| arm_to_mem | input | 1 | 1: storage-to-memory, 0: memory-to-storage |
| arm_bytes | input | BYTES_W | Command byte budget |
| arm_lba | input | 32 | First sector address |
| go | input | 1 | Start strobe (taken in ARMED) |
| go_table | input | 32 | Descriptor table base |
| abort | input | 1 | Cancel the command |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Request writes memory |
| mem_addr | output | 32 | Request address |
| mem_len | output | 17 | Request length in bytes |
| mem_busy | input | 1 | Memory port busy |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 64 | Descriptor word returned with the acknowledge |
| stor_stb | output | 1 | One storage sector step |
| stor_wr | output | 1 | Sector is written to storage |
| stor_lba | output | 32 | Sector address of the step |
| done | output | 1 | Command finished cleanly |
| err | output | 1 | Command ended in error |
| err_code | output | 3 | 1 abort, 2 misaligned, 3 over budget, 4 unused budget |
| phase | output | 2 | 0 idle, 1 armed, 2 transfer |

## Verification
The hardest situations to reach are the timing ones: the back-off retry, and a data transfer that is cut short while the latency counter is still running. For the back-off, the bench holds `mem_busy` high across the start strobe and drops it while the engine sits in back-off. It then measures the cycle of the first fetch against the first transfer cycle. For the cut-short transfer, the bench uses an eight-sector descriptor, so the latency window is 32 cycles. It issues `abort` right after the data request is seen, and expects no storage strobe to follow.

// File: rtl/sgdma_pkg.sv
`timescale 1ns/1ps
package sgdma_pkg;
    localparam int SEC_SHIFT  = 9;
    localparam int SEC_BYTES  = 1 << SEC_SHIFT;
    localparam int DESC_BYTES = 8;
    localparam int CNT_W      = 17;
    localparam int SEC_W      = CNT_W - SEC_SHIFT;

    typedef enum logic [3:0] {
        S_IDLE, S_ARMED, S_FETCH_REQ, S_FETCH_BO, S_FETCH_WAIT, S_DESC_CHK,
        S_XFER_REQ, S_XFER_BO, S_XFER_WAIT, S_SECT, S_NEXT
    } state_t;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_ABORT    = 3'd1,
        ERR_ALIGN    = 3'd2,
        ERR_BUDGET   = 3'd3,
        ERR_LEFTOVER = 3'd4
    } err_t;

    typedef struct packed {
        logic             eot;
        logic [CNT_W-1:0] len;
        logic [31:0]      base;
    } desc_t;

    function automatic desc_t unpack_desc(input logic [63:0] w);
        desc_t d;
        d.eot  = w[63];
        d.len  = (w[47:32] == 16'd0) ? CNT_W'(65536) : {1'b0, w[47:32]};
        d.base = {w[31:1], 1'b0};
        return d;
    endfunction
endpackage

// File: rtl/sgdma_backoff.sv
`timescale 1ns/1ps
module sgdma_backoff #(
    parameter int BACKOFF = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int BO_W = (BACKOFF < 2) ? 1 : $clog2(BACKOFF);

    logic [BO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= BO_W'(BACKOFF - 1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sgdma_latency.sv
`timescale 1ns/1ps
module sgdma_latency #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sgdma_budget.sv
`timescale 1ns/1ps
module sgdma_budget
    import sgdma_pkg::*;
#(
    parameter int BYTES_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_cmd,
    input  logic [BYTES_W-1:0] cmd_bytes,
    input  logic [31:0]        cmd_lba,
    input  logic               load_desc,
    input  logic [SEC_W-1:0]   desc_secs,
    input  logic               step,
    output logic [BYTES_W-1:0] remain,
    output logic [31:0]        lba,
    output logic [SEC_W-1:0]   secs_left
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain    <= '0;
            lba       <= '0;
            secs_left <= '0;
        end else begin
            if (load_cmd) begin
                remain <= cmd_bytes;
                lba    <= cmd_lba;
            end else if (step) begin
                remain <= remain - BYTES_W'(SEC_BYTES);
                lba    <= lba + 32'd1;
            end
            if (load_desc)
                secs_left <= desc_secs;
            else if (step)
                secs_left <= secs_left - 1'b1;
        end
    end
endmodule

// File: rtl/sgdma_engine.sv
`timescale 1ns/1ps
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int BYTES_W    = 18,
    parameter int BACKOFF    = 6,
    parameter int SECTOR_LAT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               arm_to_mem,
    input  logic [BYTES_W-1:0] arm_bytes,
    input  logic [31:0]        arm_lba,
    input  logic               go,
    input  logic [31:0]        go_table,
    input  logic               abort,
    output logic               mem_req,
    output logic               mem_we,
    output logic [31:0]        mem_addr,
    output logic [CNT_W-1:0]   mem_len,
    input  logic               mem_busy,
    input  logic               mem_ack,
    input  logic [63:0]        mem_rdata,
    output logic               stor_stb,
    output logic               stor_wr,
    output logic [31:0]        stor_lba,
    output logic               done,
    output logic               err,
    output logic [2:0]         err_code,
    output logic [1:0]         phase
);
    localparam int MAX_SECS = 1 << SEC_W;
    localparam int LAT_MAX  = MAX_SECS * ((SECTOR_LAT < 1) ? 1 : SECTOR_LAT);
    localparam int LAT_W    = $clog2(LAT_MAX + 1);

    state_t state_q, nxt;
    logic   to_mem_q;
    logic   [31:0] ptr_q;
    desc_t  desc_q;
    logic   ack_seen_q;
    logic   done_q, err_q;
    err_t   code_q;

    // control strobes from the next-state logic
    logic ld_cmd, ld_desc, step, bo_start, lat_load, ptr_load, desc_cap;
    logic fin_done;
    err_t fin_err;

    logic               bo_expired, lat_zero;
    logic [BYTES_W-1:0] remain;
    logic [31:0]        lba;
    logic [SEC_W-1:0]   secs_left;
    logic [SEC_W-1:0]   desc_secs;

    assign desc_secs = desc_q.len[CNT_W-1:SEC_SHIFT];

    sgdma_backoff #(.BACKOFF(BACKOFF)) u_backoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (bo_start),
        .expired (bo_expired)
    );

    generate
        if (SECTOR_LAT == 0) begin : g_no_lat
            assign lat_zero = 1'b1;
        end else begin : g_lat
            logic [LAT_W-1:0] lat_val;
            assign lat_val = LAT_W'(desc_secs) * LAT_W'(SECTOR_LAT);
            sgdma_latency #(.W(LAT_W)) u_latency (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (lat_load),
                .val   (lat_val),
                .zero  (lat_zero)
            );
        end
    endgenerate

    sgdma_budget #(.BYTES_W(BYTES_W)) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_cmd  (ld_cmd),
        .cmd_bytes (arm_bytes),
        .cmd_lba   (arm_lba),
        .load_desc (ld_desc),
        .desc_secs (desc_secs),
        .step      (step),
        .remain    (remain),
        .lba       (lba),
        .secs_left (secs_left)
    );

    // next state and control strobes
    always_comb begin
        nxt      = state_q;
        ld_cmd   = 1'b0;
        ld_desc  = 1'b0;
        step     = 1'b0;
        bo_start = 1'b0;
        lat_load = 1'b0;
        ptr_load = 1'b0;
        desc_cap = 1'b0;
        fin_done = 1'b0;
        fin_err  = ERR_NONE;
        unique case (state_q)
            S_IDLE: begin
                if (arm) begin
                    nxt    = S_ARMED;
                    ld_cmd = 1'b1;
                end
            end
            S_ARMED: begin
                if (go) begin
                    nxt      = S_FETCH_REQ;
                    ptr_load = 1'b1;
                end
            end
            S_FETCH_REQ: begin
                if (mem_busy) begin
                    nxt      = S_FETCH_BO;
                    bo_start = 1'b1;
                end else begin
                    nxt = S_FETCH_WAIT;
                end
            end
            S_FETCH_BO: begin
                if (bo_expired)
                    nxt = S_FETCH_REQ;
            end
            S_FETCH_WAIT: begin
                if (mem_ack) begin
                    nxt      = S_DESC_CHK;
                    desc_cap = 1'b1;
                end
            end
            S_DESC_CHK: begin
                if (desc_q.len[SEC_SHIFT-1:0] != '0) begin
                    nxt     = S_IDLE;
                    fin_err = ERR_ALIGN;
                end else if (BYTES_W'(desc_q.len) > remain ||
                             (BYTES_W <= CNT_W && desc_q.len[CNT_W-1])) begin
                    nxt     = S_IDLE;
                    fin_err = ERR_BUDGET;
                end else begin
                    ld_desc = 1'b1;
                    nxt     = to_mem_q ? S_SECT : S_XFER_REQ;
                end
            end
            S_XFER_REQ: begin
                if (mem_busy) begin
                    nxt      = S_XFER_BO;
                    bo_start = 1'b1;
                end else begin
                    nxt      = S_XFER_WAIT;
                    lat_load = 1'b1;
                end
            end
            S_XFER_BO: begin
                if (bo_expired)
                    nxt = S_XFER_REQ;
            end
            S_XFER_WAIT: begin
                if ((ack_seen_q || mem_ack) && lat_zero)
                    nxt = to_mem_q ? S_NEXT : S_SECT;
            end
            S_SECT: begin
                step = 1'b1;
                if (secs_left == SEC_W'(1))
                    nxt = to_mem_q ? S_XFER_REQ : S_NEXT;
            end
            S_NEXT: begin
                if (!desc_q.eot) begin
                    nxt = S_FETCH_REQ;
                end else if (remain == '0) begin
                    nxt      = S_IDLE;
                    fin_done = 1'b1;
                end else begin
                    nxt     = S_IDLE;
                    fin_err = ERR_LEFTOVER;
                end
            end
            default: nxt = S_IDLE;
        endcase
        if (abort && state_q != S_IDLE) begin
            nxt      = S_IDLE;
            fin_done = 1'b0;
            fin_err  = ERR_ABORT;
            step     = 1'b0;
            ld_desc  = 1'b0;
            lat_load = 1'b0;
            bo_start = 1'b0;
            desc_cap = 1'b0;
            ptr_load = 1'b0;
        end
    end

    // state register and command context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            to_mem_q   <= 1'b0;
            ptr_q      <= '0;
            desc_q     <= '0;
            ack_seen_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            code_q     <= ERR_NONE;
        end else begin
            state_q <= nxt;
            done_q  <= fin_done;
            err_q   <= (fin_err != ERR_NONE);
            code_q  <= fin_err;
            if (ld_cmd)
                to_mem_q <= arm_to_mem;
            if (ptr_load)
                ptr_q <= go_table;
            else if (desc_cap)
                ptr_q <= ptr_q + 32'(DESC_BYTES);
            if (desc_cap)
                desc_q <= unpack_desc(mem_rdata);
            if (lat_load)
                ack_seen_q <= 1'b0;
            else if (state_q == S_XFER_WAIT && mem_ack)
                ack_seen_q <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = desc_q.base;
        mem_len  = desc_q.len;
        stor_stb = 1'b0;
        phase    = 2'd2;
        unique case (state_q)
            S_IDLE:      phase = 2'd0;
            S_ARMED:     phase = 2'd1;
            S_FETCH_REQ: begin
                mem_req  = !mem_busy;
                mem_addr = ptr_q;
                mem_len  = CNT_W'(DESC_BYTES);
            end
            S_XFER_REQ: begin
                mem_req = !mem_busy;
                mem_we  = to_mem_q;
            end
            S_SECT:      stor_stb = 1'b1;
            default: ;
        endcase
    end

    assign stor_wr  = !to_mem_q;
    assign stor_lba = lba;
    assign done     = done_q;
    assign err      = err_q;
    assign err_code = code_q;
endmodule

// File: rtl/sgdma_checker.sv
`timescale 1ns/1ps
module sgdma_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [16:0] mem_len,
    input logic        mem_busy,
    input logic        stor_stb,
    input logic        done,
    input logic        err,
    input logic [2:0]  err_code,
    input logic [1:0]  phase
);
    assert_idle_no_jump_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd0) |=> (phase != 2'd2));

    assert_fetch_is_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_len == 17'd8) |-> !mem_we);

    assert_no_req_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_busy);

    assert_stb_in_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stor_stb |-> (phase == 2'd2));

    assert_code_on_err_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 3'd0));

    assert_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    assert_end_in_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> (phase == 2'd0));

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    assert_quiet_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> (err_code == 3'd0));
endmodule

bind sgdma_engine sgdma_checker u_sgdma_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_len  (mem_len),
    .mem_busy (mem_busy),
    .stor_stb (stor_stb),
    .done     (done),
    .err      (err),
    .err_code (err_code),
    .phase    (phase)
);

// File: tb/tb_sgdma_engine.sv
`timescale 1ns/1ps
module tb_sgdma_engine;
    localparam int BACKOFF = 6;
    localparam int LAT     = 4;
    localparam logic [31:0] TBL = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 0, arm_to_mem = 0, go = 0, abort = 0;
    logic [17:0] arm_bytes = '0;
    logic [31:0] arm_lba = '0, go_table = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [16:0] mem_len;
    logic        mem_busy = 0, mem_ack = 0;
    logic [63:0] mem_rdata = '0;
    logic        stor_stb, stor_wr;
    logic [31:0] stor_lba;
    logic        done, err;
    logic [2:0]  err_code;
    logic [1:0]  phase;

    always #2 clk = ~clk;

    sgdma_engine #(.BYTES_W(18), .BACKOFF(BACKOFF), .SECTOR_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .arm_to_mem(arm_to_mem),
        .arm_bytes(arm_bytes), .arm_lba(arm_lba), .go(go), .go_table(go_table),
        .abort(abort), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_busy(mem_busy), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .stor_stb(stor_stb), .stor_wr(stor_wr),
        .stor_lba(stor_lba), .done(done), .err(err), .err_code(err_code),
        .phase(phase)
    );

    int total = 0, bad = 0, cyc = 0;
    logic [63:0] desc_mem [0:15];

    // monitor log
    int n_fetch, n_data, n_stor, busy_viol, xfer_cyc, f_cyc, d_cyc, s_cyc;
    logic [31:0] fetch_addr [0:7];
    logic [31:0] d_addr, s_first, s_prev;
    int d_len;
    logic d_we, s_wr, seq_bad;
    int pend = 0;
    logic [63:0] pend_data = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] mkd(input logic eot, input int cnt, input logic [31:0] base);
        logic [15:0] c16 = cnt[15:0];
        return {eot, 15'd0, c16, base};
    endfunction

    function automatic logic [63:0] lookup(input logic [31:0] a);
        if (a >= TBL && a < TBL + 32'd128) return desc_mem[(a - TBL) >> 3];
        return 64'd0;
    endfunction

    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                mem_ack   = 1'b1;
                mem_rdata = pend_data;
            end
        end
        if (mem_req) begin
            if (mem_busy) busy_viol++;
            pend = 1;
            pend_data = lookup(mem_addr);
            if (mem_len == 17'd8) begin
                if (n_fetch == 0) f_cyc = cyc;
                if (n_fetch < 8) fetch_addr[n_fetch] = mem_addr;
                n_fetch++;
            end else begin
                if (n_data == 0) begin
                    d_cyc = cyc; d_addr = mem_addr; d_len = int'(mem_len); d_we = mem_we;
                end
                n_data++;
            end
        end
        if (stor_stb) begin
            if (n_stor == 0) begin
                s_first = stor_lba; s_cyc = cyc; s_wr = stor_wr;
            end else if (stor_lba != s_prev + 32'd1) seq_bad = 1'b1;
            s_prev = stor_lba;
            n_stor++;
        end
        if (phase == 2'd2 && xfer_cyc < 0) xfer_cyc = cyc;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_log();
        n_fetch = 0; n_data = 0; n_stor = 0; busy_viol = 0; xfer_cyc = -1;
        f_cyc = 0; d_cyc = 0; s_cyc = 0; seq_bad = 0; d_len = 0; d_we = 0;
        for (int i = 0; i < 16; i++) desc_mem[i] = '0;
    endtask

    task automatic start_cmd(input logic to_mem, input int bytes, input logic [31:0] lba);
        @(negedge clk);
        arm = 1; arm_to_mem = to_mem; arm_bytes = 18'(bytes); arm_lba = lba;
        @(negedge clk);
        arm = 0;
        check(phase == 2'd1, "R1 armed phase", phase, 1);
        go = 1; go_table = TBL;
        @(negedge clk);
        go = 0;
    endtask

    task automatic wait_end(output bit got_done, output bit got_err, output int code);
        got_done = 0; got_err = 0; code = 0;
        for (int i = 0; i < 4000; i++) begin
            if (done || err) begin
                got_done = done; got_err = err; code = int'(err_code);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(phase == 2'd0 && !done && !err && !mem_req && !stor_stb,
              "R1 reset state", phase, 0);
    endtask

    task automatic t_single_to_disk();
        bit gd, ge; int code;
        clear_log();
        desc_mem[0] = mkd(1, 2048, 32'h0000_2001);
        start_cmd(0, 2048, 32'd100);
        wait_end(gd, ge, code);
        check(gd && !ge, "R8 done single", gd, 1);
        check(fetch_addr[0] == TBL && n_fetch == 1, "R2 fetch addr", fetch_addr[0], TBL);
        check(d_addr == 32'h0000_2000, "R3 base bit0 ignored", d_addr, 32'h2000);
        check(d_len == 2048 && d_we == 0, "R4 to-disk request", d_len, 2048);
        check(s_wr == 1 && s_cyc > d_cyc, "R4 strobes after transfer", s_cyc, d_cyc + 1);
        check(n_stor == 4 && s_first == 32'd100 && !seq_bad, "R6 sectors", n_stor, 4);
        check(s_cyc - d_cyc == 4 * LAT + 2, "R7 latency", s_cyc - d_cyc, 4 * LAT + 2);
        @(negedge clk);
        check(!done && !err, "R13 single-cycle pulse", done, 0);
    endtask

    task automatic t_chain_to_mem();
        bit gd, ge; int code;
        clear_log();
        desc_mem[0] = mkd(0, 512, 32'h0000_3000);
        desc_mem[1] = mkd(1, 1024, 32'h0000_4000);
        start_cmd(1, 1536, 32'd7);
        wait_end(gd, ge, code);
        check(gd && !ge, "R8 chain done", gd, 1);
        check(n_fetch == 2 && fetch_addr[1] == TBL + 32'd8, "R2 pointer +8", fetch_addr[1], TBL + 8);
        check(n_data == 2 && d_we == 1 && s_wr == 0, "R4 to-mem request", d_we, 1);
        check(s_cyc < d_cyc, "R4 strobes before request", s_cyc, d_cyc - 1);
        check(n_stor == 3 && s_first == 32'd7 && !seq_bad, "R6 chained sectors", n_stor, 3);
    endtask

    task automatic t_full_count();
        bit gd, ge; int code;
        clear_log();
        desc_mem[0] = mkd(1, 0, 32'h0001_0000);
        start_cmd(1, 65536, 32'd0);
        wait_end(gd, ge, code);
        check(gd && d_len == 65536, "R3 zero count means 65536", d_len, 65536);
        check(n_stor == 128 && !seq_bad, "R6 full sectors", n_stor, 128);
    endtask

    task automatic t_misaligned();
        bit gd, ge; int code;
        clear_log();
        desc_mem[0] = mkd(1, 700, 32'h0000_2000);
        start_cmd(0, 2048, 32'd0);
        wait_end(gd, ge, code);
        check(ge && code == 2 && !gd, "R9 misaligned code", code, 2);
        check(n_data == 0 && n_stor == 0, "R9 no data request", n_data, 0);
    endtask

    task automatic t_over_budget();
        bit gd, ge; int code;
        clear_log();
        desc_mem[0] = mkd(1, 1024, 32'h0000_2000);
        start_cmd(1, 512, 32'd0);
        wait_end(gd, ge, code);
        check(ge && code == 3, "R10 over-budget code", code, 3);
        check(n_data == 0 && n_stor == 0, "R10 no data request", n_data, 0);
    endtask

    task automatic t_leftover();
        bit gd, ge; int code;
        clear_log();
        desc_mem[0] = mkd(1, 512, 32'h0000_2000);
        start_cmd(0, 1024, 32'd0);
        wait_end(gd, ge, code);
        check(ge && !gd && code == 4, "R11 unused budget code", code, 4);
        check(n_stor == 1, "R11 one sector moved", n_stor, 1);
    endtask

    task automatic t_backoff();
        bit gd, ge; int code;
        clear_log();
        desc_mem[0] = mkd(1, 512, 32'h0000_2000);
        mem_busy = 1;
        start_cmd(0, 512, 32'd0);
        repeat (2) @(negedge clk);
        mem_busy = 0;
        wait_end(gd, ge, code);
        check(gd, "R5 done after back-off", gd, 1);
        check(f_cyc - xfer_cyc == BACKOFF + 1, "R5 retry time", f_cyc - xfer_cyc, BACKOFF + 1);
        check(busy_viol == 0, "R5 no request while busy", busy_viol, 0);
    endtask

    task automatic t_abort_cases();
        bit gd, ge; int code; bit seen;
        clear_log();
        @(negedge clk); abort = 1;
        @(negedge clk); abort = 0;
        seen = 0;
        repeat (3) begin
            if (err) seen = 1;
            @(negedge clk);
        end
        check(!seen && phase == 2'd0, "R12 abort in idle ignored", seen, 0);
        go = 1; go_table = TBL;
        @(negedge clk); go = 0;
        repeat (4) @(negedge clk);
        check(phase == 2'd0 && n_fetch == 0, "R1 go in idle ignored", n_fetch, 0);
        arm = 1; arm_to_mem = 0; arm_bytes = 18'd512; arm_lba = 0;
        @(negedge clk); arm = 0; abort = 1;
        @(negedge clk); abort = 0;
        wait_end(gd, ge, code);
        check(ge && code == 1, "R12 abort when armed", code, 1);
    endtask

    task automatic t_abort_mid();
        bit gd, ge; int code;
        clear_log();
        desc_mem[0] = mkd(1, 4096, 32'h0000_2000);
        start_cmd(0, 4096, 32'd0);
        for (int i = 0; i < 100 && n_data == 0; i++) @(negedge clk);
        abort = 1;
        @(negedge clk); abort = 0;
        wait_end(gd, ge, code);
        check(ge && code == 1 && !gd, "R12 abort in transfer", code, 1);
        repeat (40) @(negedge clk);
        check(n_stor == 0 && phase == 2'd0, "R12 no strobes after abort", n_stor, 0);
    endtask

    initial begin
        clear_log();
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_single_to_disk();
        t_chain_to_mem();
        t_full_count();
        t_misaligned();
        t_over_budget();
        t_leftover();
        t_backoff();
        t_abort_cases();
        t_abort_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule